// File: doc/BRIEF.md
# Register Scoreboard with Dependent Wakeup

This block tracks operand readiness for the instructions that wait in an issue window. It keeps one ready bit for each physical register. For each register it also keeps the set of waiting consumer operands, stored as one row of a bit matrix with one column per (slot, source) pair. When an instruction is written into a slot, each source that is still unready is checked against the scoreboard. If the scoreboard already shows the register ready, the source counts as ready at once. Otherwise the source is linked into that register's row. Each destination of the instruction clears its scoreboard bit, which makes the instruction the register's pending producer.

When a producer completes, every operand linked to its destination register is woken in one cycle and the row is emptied. The register is then marked ready, and the number of woken operands is reported on the following cycle. Each slot has a counter of ready sources. A slot whose counter reaches the source count is reported ready, either to the execution side or, for memory operations, to the memory-ordering side. A thread-selective squash cancels every slot younger than a given sequence number and unlinks only the operands those slots still had waiting.

Instructions with ordering side effects (non-speculative operations, store-conditionals, barriers) are never linked. They wait in a pending set until an explicit release arrives, and a squash also removes them from that set.

Top module: `dep_wakeup_scoreboard`

## Requirements
- R1: After reset, every register ready bit is 0, no slot is ready or pending, and `woken_count` and `producer_fault` are 0.
- R2: At insert, a source counts as ready without being linked if either of two conditions holds: its `ins_src_ok` bit is 1, or its register's ready bit is already 1. A later completion of that register does not count it as woken.
- R3: Inserting with `ins_dst_en` = 1 clears the ready bit of a tracked `ins_dst` at the same clock edge.
- R4: Inserting a producer for a register that still has linked waiters, and that is not completing in the same cycle, raises `producer_fault` for exactly one cycle, one cycle after the insert. It stays 0 otherwise.
- R5: Register indices at or above NREGS are never tracked. A source with such an index counts as ready, a completion with such an index wakes nobody and changes no ready bit, and a destination with such an index changes no ready bit.
- R6: A completion of tracked register r sets ready bit r and wakes every operand linked to r. `woken_count` shows the number of woken operands one cycle later and is 0 in cycles that follow no completion.
- R7: A valid slot whose sources are all ready is shown on `exec_ready` if it was inserted with `ins_mem` = 0, or on `mem_ready` if it was inserted with `ins_mem` = 1.
- R8: A squash of thread t at point p cancels every valid slot of thread t whose sequence number, compared unsigned, is greater than p. Slots with a sequence number equal to or below p, and slots of other threads, are untouched.
- R9: A cancelled slot keeps no links, so a later completion does not count it as woken.
- R10: An insert with `ins_nonspec` = 1 links no sources and shows on `nonspec_pending`. It becomes ready only after `rel_valid` names its slot. A squash that cancels it removes it from `nonspec_pending`.
- R11: `drop_valid` frees a slot and removes its links. A slot may only be inserted into while it is free.
- R12: When a completion and an insert arrive in the same cycle, the insert treats the completing register as ready. If the insert's destination is that same register, the insert's clear wins and the ready bit ends at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Insert an instruction this cycle |
| ins_slot | input | SLOT_W | Free slot that receives the instruction |
| ins_tid | input | TID_W | Thread of the instruction |
| ins_seq | input | SEQ_W | Sequence number (larger is younger) |
| ins_src | input | NSRCS*RIDX_W | Source register indices; source k is at bits [k*RIDX_W +: RIDX_W] |
| ins_src_ok | input | NSRCS | Source already known ready by the rename stage |
| ins_dst | input | RIDX_W | Destination register index |
| ins_dst_en | input | 1 | Instruction writes `ins_dst` |
| ins_mem | input | 1 | Memory operation; readiness goes to `mem_ready` |
| ins_nonspec | input | 1 | Ordering-sensitive instruction that waits for release |
| rel_valid | input | 1 | Release the pending instruction in `rel_slot` |
| rel_slot | input | SLOT_W | Slot to release |
| done_valid | input | 1 | A producer completed |
| done_dst | input | RIDX_W | Destination register of the completing producer |
| drop_valid | input | 1 | Free a slot (instruction has left the window) |
| drop_slot | input | SLOT_W | Slot to free |
| sq_valid | input | 1 | Squash request |
| sq_tid | input | TID_W | Thread to squash |
| sq_seq | input | SEQ_W | Squash point; younger entries are cancelled |
| reg_ready | output | NREGS | Scoreboard ready bit for each register |
| exec_ready | output | NSLOTS | Non-memory slot with all sources ready |
| mem_ready | output | NSLOTS | Memory slot with all sources ready |
| nonspec_pending | output | NSLOTS | Ordering-sensitive slot not yet released |
| woken_count | output | WC_W | Operands woken by the previous cycle's completion |
| producer_fault | output | 1 | Previous cycle inserted a producer over live waiters |

## Verification
Two invariants are checked on every cycle. First, the assertions confirm that each valid slot's ready counter plus its linked operand bits add up to the source count. Second, they confirm that a free or cancelled slot owns no column in the wait matrix. They also check, cycle by cycle, that a completion sets its ready bit and a destination insert clears it, and that a matching squash empties the slot. The bench's scenarios cover the behaviours that need a chosen history. These are: operands caught by the scoreboard check at insert, the squash boundary at an equal sequence number, isolation between threads, untracked register indices, held and released ordering-sensitive entries, and the same-cycle collision of a completion with an insert.

// File: rtl/sbw_pkg.sv
package sbw_pkg;

  typedef enum logic {
    SK_EXEC = 1'b0,
    SK_MEM  = 1'b1
  } slot_kind_e;

  // A register index is tracked only when it lies inside the physical range.
  function automatic logic idx_tracked(input logic [31:0] idx, input int unsigned nregs);
    return idx < nregs;
  endfunction

  // Population count over up to 64 bits.
  function automatic int unsigned bit_total(input logic [63:0] v);
    int unsigned n;
    n = 0;
    for (int i = 0; i < 64; i++) n += v[i] ? 1 : 0;
    return n;
  endfunction

  // True when sequence s is younger than the squash point p.
  function automatic logic seq_younger(input logic [31:0] s, input logic [31:0] p);
    return s > p;
  endfunction

endpackage

// File: rtl/sbw_ready_bits.sv
module sbw_ready_bits
  import sbw_pkg::*;
#(
  parameter int NREGS  = 16,
  parameter int RIDX_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_en,
  input  logic [RIDX_W-1:0] set_idx,
  input  logic              clr_en,
  input  logic [RIDX_W-1:0] clr_idx,
  output logic [NREGS-1:0]  ready_q,
  output logic [NREGS-1:0]  ready_fwd
);
  localparam int PW = (NREGS > 1) ? $clog2(NREGS) : 1;

  logic [PW-1:0]    set_lo, clr_lo;
  logic             set_hit, clr_hit;
  logic [NREGS-1:0] ready_d;

  assign set_lo  = set_idx[PW-1:0];
  assign clr_lo  = clr_idx[PW-1:0];
  assign set_hit = set_en && idx_tracked(32'(set_idx), NREGS);
  assign clr_hit = clr_en && idx_tracked(32'(clr_idx), NREGS);

  // Completion is visible to same-cycle inserts; the insert's clear wins.
  always_comb begin
    ready_fwd = ready_q;
    if (set_hit) ready_fwd[set_lo] = 1'b1;
    ready_d = ready_fwd;
    if (clr_hit) ready_d[clr_lo] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ready_q <= '0;
    else        ready_q <= ready_d;
  end

  assert_done_marks_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (set_hit && !(clr_hit && clr_idx == set_idx)) |=> ready_q[$past(set_lo)]);

  assert_insert_clears_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
    clr_hit |=> !ready_q[$past(clr_lo)]);

endmodule

// File: rtl/sbw_wait_matrix.sv
module sbw_wait_matrix
  import sbw_pkg::*;
#(
  parameter int NREGS  = 16,
  parameter int NSLOTS = 8,
  parameter int NSRCS  = 2,
  parameter int RIDX_W = 5,
  parameter int SLOT_W = 3,
  localparam int NCOLS = NSLOTS * NSRCS
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    link_en,
  input  logic [SLOT_W-1:0]       link_slot,
  input  logic [NSRCS*RIDX_W-1:0] link_src,
  input  logic [NSRCS-1:0]        link_need,
  input  logic                    wake_en,
  input  logic [RIDX_W-1:0]       wake_idx,
  input  logic [NSLOTS-1:0]       kill_slots,
  input  logic [RIDX_W-1:0]       probe_idx,
  output logic [NCOLS-1:0]        wake_cols,
  output logic [NCOLS-1:0]        col_waiting,
  output logic                    probe_busy
);
  localparam int PW = (NREGS > 1) ? $clog2(NREGS) : 1;

  logic [NCOLS-1:0] row_q [NREGS];
  logic [NCOLS-1:0] kill_cols;
  logic             wake_hit;

  assign wake_hit = wake_en && idx_tracked(32'(wake_idx), NREGS);

  for (genvar s = 0; s < NSLOTS; s++) begin : g_kill
    assign kill_cols[s*NSRCS +: NSRCS] = {NSRCS{kill_slots[s]}};
  end

  always_comb begin
    wake_cols = '0;
    if (wake_hit) wake_cols = row_q[wake_idx[PW-1:0]];
    probe_busy = 1'b0;
    if (idx_tracked(32'(probe_idx), NREGS))
      probe_busy = |row_q[probe_idx[PW-1:0]] && !(wake_hit && wake_idx == probe_idx);
    col_waiting = '0;
    for (int r = 0; r < NREGS; r++) col_waiting |= row_q[r];
  end

  for (genvar r = 0; r < NREGS; r++) begin : g_row
    logic [NCOLS-1:0] link_r;
    logic             clear_r;
    for (genvar s = 0; s < NSLOTS; s++) begin : g_slot
      for (genvar k = 0; k < NSRCS; k++) begin : g_src
        assign link_r[s*NSRCS+k] = link_en && link_need[k] &&
                                   link_slot == SLOT_W'(s) &&
                                   link_src[k*RIDX_W +: RIDX_W] == RIDX_W'(r);
      end
    end
    assign clear_r = wake_hit && wake_idx == RIDX_W'(r);
    always_ff @(posedge clk) begin
      if (!rst_n) row_q[r] <= '0;
      else        row_q[r] <= (row_q[r] & ~kill_cols & ~{NCOLS{clear_r}}) | link_r;
    end
  end

endmodule

// File: rtl/sbw_slot_table.sv
module sbw_slot_table
  import sbw_pkg::*;
#(
  parameter int NSLOTS = 8,
  parameter int NSRCS  = 2,
  parameter int SLOT_W = 3,
  parameter int TID_W  = 1,
  parameter int SEQ_W  = 8,
  parameter int CNT_W  = 2,
  localparam int NCOLS = NSLOTS * NSRCS
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ins_en,
  input  logic [SLOT_W-1:0]       ins_slot,
  input  logic [TID_W-1:0]        ins_tid,
  input  logic [SEQ_W-1:0]        ins_seq,
  input  logic [CNT_W-1:0]        ins_cnt,
  input  slot_kind_e              ins_kind,
  input  logic                    ins_hold,
  input  logic                    rel_en,
  input  logic [SLOT_W-1:0]       rel_slot,
  input  logic                    drop_en,
  input  logic [SLOT_W-1:0]       drop_slot,
  input  logic                    sq_en,
  input  logic [TID_W-1:0]        sq_tid,
  input  logic [SEQ_W-1:0]        sq_seq,
  input  logic [NCOLS-1:0]        wake_cols,
  output logic [NSLOTS-1:0]       kill_slots,
  output logic [NSLOTS-1:0]       slot_valid,
  output logic [NSLOTS*CNT_W-1:0] slot_cnt,
  output logic [NSLOTS-1:0]       exec_rdy,
  output logic [NSLOTS-1:0]       mem_rdy,
  output logic [NSLOTS-1:0]       hold_vec
);

  for (genvar s = 0; s < NSLOTS; s++) begin : g_slot
    logic             v_q, hold_q, sq_hit;
    slot_kind_e       kind_q;
    logic [TID_W-1:0] tid_q;
    logic [SEQ_W-1:0] seq_q;
    logic [CNT_W-1:0] cnt_q, hits;
    logic             all_rdy;

    assign hits   = CNT_W'(bit_total(64'(wake_cols[s*NSRCS +: NSRCS])));
    assign sq_hit = sq_en && tid_q == sq_tid && seq_younger(32'(seq_q), 32'(sq_seq));
    assign kill_slots[s] = v_q && (sq_hit || (drop_en && drop_slot == SLOT_W'(s)));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        v_q    <= 1'b0;
        hold_q <= 1'b0;
        kind_q <= SK_EXEC;
        tid_q  <= '0;
        seq_q  <= '0;
        cnt_q  <= '0;
      end else if (ins_en && ins_slot == SLOT_W'(s)) begin
        v_q    <= 1'b1;
        hold_q <= ins_hold;
        kind_q <= ins_kind;
        tid_q  <= ins_tid;
        seq_q  <= ins_seq;
        cnt_q  <= ins_cnt;
      end else if (kill_slots[s]) begin
        v_q    <= 1'b0;
        hold_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q + hits;
        if (rel_en && rel_slot == SLOT_W'(s)) hold_q <= 1'b0;
      end
    end

    assign all_rdy     = v_q && cnt_q == CNT_W'(NSRCS) && !hold_q;
    assign exec_rdy[s] = all_rdy && kind_q == SK_EXEC;
    assign mem_rdy[s]  = all_rdy && kind_q == SK_MEM;
    assign hold_vec[s] = v_q && hold_q;
    assign slot_valid[s] = v_q;
    assign slot_cnt[s*CNT_W +: CNT_W] = cnt_q;

    assert_counter_bounded_R6: assert property (@(posedge clk) disable iff (!rst_n)
      v_q |-> (32'(cnt_q) <= NSRCS));

    assert_insert_into_free_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (ins_en && ins_slot == SLOT_W'(s)) |-> !v_q);

    assert_squash_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (v_q && sq_hit && !(ins_en && ins_slot == SLOT_W'(s))) |=> !v_q);
  end

endmodule

// File: rtl/dep_wakeup_scoreboard.sv
module dep_wakeup_scoreboard
  import sbw_pkg::*;
#(
  parameter int NREGS    = 16,
  parameter int NSLOTS   = 8,
  parameter int NSRCS    = 2,
  parameter int NTHREADS = 2,
  parameter int SEQ_W    = 8,
  localparam int RIDX_W  = $clog2(NREGS) + 1,
  localparam int SLOT_W  = (NSLOTS > 1) ? $clog2(NSLOTS) : 1,
  localparam int TID_W   = (NTHREADS > 1) ? $clog2(NTHREADS) : 1,
  localparam int CNT_W   = $clog2(NSRCS + 1),
  localparam int NCOLS   = NSLOTS * NSRCS,
  localparam int WC_W    = $clog2(NCOLS + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ins_valid,
  input  logic [SLOT_W-1:0]       ins_slot,
  input  logic [TID_W-1:0]        ins_tid,
  input  logic [SEQ_W-1:0]        ins_seq,
  input  logic [NSRCS*RIDX_W-1:0] ins_src,
  input  logic [NSRCS-1:0]        ins_src_ok,
  input  logic [RIDX_W-1:0]       ins_dst,
  input  logic                    ins_dst_en,
  input  logic                    ins_mem,
  input  logic                    ins_nonspec,
  input  logic                    rel_valid,
  input  logic [SLOT_W-1:0]       rel_slot,
  input  logic                    done_valid,
  input  logic [RIDX_W-1:0]       done_dst,
  input  logic                    drop_valid,
  input  logic [SLOT_W-1:0]       drop_slot,
  input  logic                    sq_valid,
  input  logic [TID_W-1:0]        sq_tid,
  input  logic [SEQ_W-1:0]        sq_seq,
  output logic [NREGS-1:0]        reg_ready,
  output logic [NSLOTS-1:0]       exec_ready,
  output logic [NSLOTS-1:0]       mem_ready,
  output logic [NSLOTS-1:0]       nonspec_pending,
  output logic [WC_W-1:0]         woken_count,
  output logic                    producer_fault
);
  localparam int PW = (NREGS > 1) ? $clog2(NREGS) : 1;

  logic [NREGS-1:0]        ready_fwd;
  logic [NSRCS-1:0]        src_ok;
  logic [CNT_W-1:0]        ins_cnt;
  logic [NCOLS-1:0]        wake_cols, col_waiting;
  logic [NSLOTS-1:0]       kill_slots, slot_valid;
  logic [NSLOTS*CNT_W-1:0] slot_cnt;
  logic                    probe_busy;
  slot_kind_e              ins_kind;

  // Classify each source: known ready, untracked, caught by scoreboard, or linked.
  always_comb begin
    logic [RIDX_W-1:0] idx;
    for (int k = 0; k < NSRCS; k++) begin
      idx = ins_src[k*RIDX_W +: RIDX_W];
      src_ok[k] = ins_src_ok[k] || ins_nonspec || !idx_tracked(32'(idx), NREGS) ||
                  ready_fwd[idx[PW-1:0]];
    end
  end

  assign ins_cnt  = CNT_W'(bit_total(64'(src_ok)));
  assign ins_kind = ins_mem ? SK_MEM : SK_EXEC;

  sbw_ready_bits #(.NREGS(NREGS), .RIDX_W(RIDX_W)) u_bits (
    .clk(clk), .rst_n(rst_n),
    .set_en(done_valid), .set_idx(done_dst),
    .clr_en(ins_valid && ins_dst_en), .clr_idx(ins_dst),
    .ready_q(reg_ready), .ready_fwd(ready_fwd)
  );

  sbw_wait_matrix #(.NREGS(NREGS), .NSLOTS(NSLOTS), .NSRCS(NSRCS),
                    .RIDX_W(RIDX_W), .SLOT_W(SLOT_W)) u_matrix (
    .clk(clk), .rst_n(rst_n),
    .link_en(ins_valid), .link_slot(ins_slot), .link_src(ins_src), .link_need(~src_ok),
    .wake_en(done_valid), .wake_idx(done_dst), .kill_slots(kill_slots),
    .probe_idx(ins_dst), .wake_cols(wake_cols), .col_waiting(col_waiting),
    .probe_busy(probe_busy)
  );

  sbw_slot_table #(.NSLOTS(NSLOTS), .NSRCS(NSRCS), .SLOT_W(SLOT_W), .TID_W(TID_W),
                   .SEQ_W(SEQ_W), .CNT_W(CNT_W)) u_slots (
    .clk(clk), .rst_n(rst_n),
    .ins_en(ins_valid), .ins_slot(ins_slot), .ins_tid(ins_tid), .ins_seq(ins_seq),
    .ins_cnt(ins_cnt), .ins_kind(ins_kind), .ins_hold(ins_nonspec),
    .rel_en(rel_valid), .rel_slot(rel_slot),
    .drop_en(drop_valid), .drop_slot(drop_slot),
    .sq_en(sq_valid), .sq_tid(sq_tid), .sq_seq(sq_seq),
    .wake_cols(wake_cols), .kill_slots(kill_slots), .slot_valid(slot_valid),
    .slot_cnt(slot_cnt), .exec_rdy(exec_ready), .mem_rdy(mem_ready),
    .hold_vec(nonspec_pending)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      woken_count    <= '0;
      producer_fault <= 1'b0;
    end else begin
      woken_count    <= WC_W'(bit_total(64'(wake_cols)));
      producer_fault <= ins_valid && ins_dst_en && probe_busy;
    end
  end

  // Cross-check between the slot counters and the wait matrix.
  for (genvar s = 0; s < NSLOTS; s++) begin : g_chk
    assert_links_balance_R6: assert property (@(posedge clk) disable iff (!rst_n)
      slot_valid[s] |->
        (32'(slot_cnt[s*CNT_W +: CNT_W]) +
         bit_total(64'(col_waiting[s*NSRCS +: NSRCS])) == NSRCS));

    assert_free_slot_unlinked_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !slot_valid[s] |-> (col_waiting[s*NSRCS +: NSRCS] == '0));
  end

endmodule

// File: tb/tb_dep_wakeup_scoreboard.sv
module tb_dep_wakeup_scoreboard;
  localparam int NREGS = 16, NSLOTS = 8, NSRCS = 2, NTHREADS = 2, SEQ_W = 8;
  localparam int RIDX_W = 5, SLOT_W = 3, TID_W = 1, WC_W = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ins_valid = 0, ins_dst_en = 0, ins_mem = 0, ins_nonspec = 0;
  logic [SLOT_W-1:0] ins_slot = '0, rel_slot = '0, drop_slot = '0;
  logic [TID_W-1:0]  ins_tid = '0, sq_tid = '0;
  logic [SEQ_W-1:0]  ins_seq = '0, sq_seq = '0;
  logic [NSRCS*RIDX_W-1:0] ins_src = '0;
  logic [NSRCS-1:0]  ins_src_ok = '0;
  logic [RIDX_W-1:0] ins_dst = '0, done_dst = '0;
  logic rel_valid = 0, done_valid = 0, drop_valid = 0, sq_valid = 0;
  logic [NREGS-1:0]  reg_ready;
  logic [NSLOTS-1:0] exec_ready, mem_ready, nonspec_pending;
  logic [WC_W-1:0]   woken_count;
  logic              producer_fault;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  dep_wakeup_scoreboard #(.NREGS(NREGS), .NSLOTS(NSLOTS), .NSRCS(NSRCS),
                          .NTHREADS(NTHREADS), .SEQ_W(SEQ_W)) dut (.*);

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic idle();
    ins_valid = 0; ins_dst_en = 0; ins_mem = 0; ins_nonspec = 0; ins_src_ok = '0;
    rel_valid = 0; done_valid = 0; drop_valid = 0; sq_valid = 0;
  endtask

  task automatic do_reset();
    idle(); rst_n = 0; step(); step(); rst_n = 1;
  endtask

  task automatic set_ins(int slot, int tid, int seq, int s0, int s1, bit ok0, bit ok1,
                         int dst, bit den, bit mem, bit ns);
    ins_valid = 1; ins_slot = 3'(slot); ins_tid = 1'(tid); ins_seq = 8'(seq);
    ins_src = {5'(s1), 5'(s0)}; ins_src_ok = {ok1, ok0};
    ins_dst = 5'(dst); ins_dst_en = den; ins_mem = mem; ins_nonspec = ns;
  endtask

  task automatic insert(int slot, int tid, int seq, int s0, int s1, bit ok0, bit ok1,
                        int dst, bit den, bit mem, bit ns);
    set_ins(slot, tid, seq, s0, s1, ok0, ok1, dst, den, mem, ns);
    step(); idle();
  endtask

  task automatic complete(int r);
    done_valid = 1; done_dst = 5'(r); step(); idle();
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 reg_ready", 64'(reg_ready), 0);
    check("R1 exec_ready", 64'(exec_ready), 0);
    check("R1 mem_ready", 64'(mem_ready), 0);
    check("R1 nonspec_pending", 64'(nonspec_pending), 0);
    check("R1 woken_count", 64'(woken_count), 0);
    check("R1 producer_fault", 64'(producer_fault), 0);
  endtask

  task automatic t_wakeup();
    do_reset();
    insert(0, 0, 1, 0, 0, 1, 1, 3, 1, 0, 0);
    check("R3 dst cleared", 64'(reg_ready[3]), 0);
    check("R7 producer ready", 64'(exec_ready), 64'h01);
    insert(1, 0, 2, 3, 3, 0, 0, 0, 0, 0, 0);
    insert(2, 0, 3, 3, 0, 0, 1, 0, 0, 1, 0);
    check("R6 waiters not ready", 64'(exec_ready | mem_ready), 64'h01);
    complete(3);
    check("R6 woken three", 64'(woken_count), 3);
    check("R6 reg ready set", 64'(reg_ready[3]), 1);
    check("R7 exec side", 64'(exec_ready), 64'h03);
    check("R7 mem side", 64'(mem_ready), 64'h04);
    step();
    check("R6 woken back to zero", 64'(woken_count), 0);
  endtask

  task automatic t_inflight();
    do_reset();
    complete(5);
    check("R6 no waiters", 64'(woken_count), 0);
    insert(4, 0, 1, 5, 0, 0, 1, 0, 0, 0, 0);
    check("R2 caught by scoreboard", 64'(exec_ready[4]), 1);
    insert(5, 0, 2, 0, 0, 1, 1, 5, 1, 0, 0);
    complete(5);
    check("R2 not linked", 64'(woken_count), 0);
  endtask

  task automatic t_fault();
    do_reset();
    insert(0, 0, 1, 7, 0, 0, 1, 0, 0, 0, 0);
    insert(1, 0, 2, 0, 0, 1, 1, 7, 1, 0, 0);
    check("R4 fault raised", 64'(producer_fault), 1);
    step();
    check("R4 fault one cycle", 64'(producer_fault), 0);
    complete(7);
    check("R4 waiter woken", 64'(woken_count), 1);
    insert(2, 0, 3, 0, 0, 1, 1, 7, 1, 0, 0);
    check("R4 no fault after wake", 64'(producer_fault), 0);
  endtask

  task automatic t_range();
    do_reset();
    insert(0, 0, 1, 20, 21, 0, 0, 0, 0, 0, 0);
    check("R5 untracked sources ready", 64'(exec_ready[0]), 1);
    complete(20);
    check("R5 untracked wake none", 64'(woken_count), 0);
    check("R5 ready bits unchanged", 64'(reg_ready), 0);
    complete(4);
    insert(1, 0, 2, 0, 0, 1, 1, 20, 1, 0, 0);
    check("R5 untracked dst", 64'(reg_ready), 64'h0010);
    check("R5 no fault", 64'(producer_fault), 0);
  endtask

  task automatic t_squash();
    do_reset();
    insert(0, 0, 10, 2, 0, 0, 1, 0, 0, 0, 0);
    insert(1, 0, 20, 2, 0, 0, 1, 0, 0, 0, 0);
    insert(2, 0, 30, 2, 2, 0, 0, 0, 0, 0, 0);
    insert(3, 1, 40, 2, 0, 0, 1, 0, 0, 0, 0);
    sq_valid = 1; sq_tid = 0; sq_seq = 8'd10; step(); idle();
    check("R8 nothing ready yet", 64'(exec_ready), 0);
    complete(2);
    check("R9 survivors woken", 64'(woken_count), 2);
    check("R8 equal seq and other thread kept", 64'(exec_ready), 64'h09);
  endtask

  task automatic t_nonspec();
    do_reset();
    insert(5, 0, 1, 9, 0, 0, 1, 0, 0, 0, 1);
    check("R10 pending", 64'(nonspec_pending), 64'h20);
    check("R10 held", 64'(exec_ready), 0);
    complete(9);
    check("R10 not linked", 64'(woken_count), 0);
    rel_valid = 1; rel_slot = 3'd5; step(); idle();
    check("R10 released pending", 64'(nonspec_pending), 0);
    check("R10 released ready", 64'(exec_ready), 64'h20);
    insert(6, 1, 50, 0, 0, 1, 1, 0, 0, 0, 1);
    sq_valid = 1; sq_tid = 1; sq_seq = 8'd49; step(); idle();
    check("R10 squash removes pending", 64'(nonspec_pending), 0);
  endtask

  task automatic t_drop();
    do_reset();
    insert(0, 0, 1, 4, 0, 0, 1, 0, 0, 0, 0);
    drop_valid = 1; drop_slot = 3'd0; step(); idle();
    complete(4);
    check("R11 dropped unlinked", 64'(woken_count), 0);
    insert(0, 0, 2, 4, 0, 0, 1, 0, 0, 0, 0);
    check("R11 slot reused", 64'(exec_ready[0]), 1);
  endtask

  task automatic t_collide();
    do_reset();
    set_ins(2, 0, 1, 6, 0, 0, 1, 0, 0, 0, 0);
    done_valid = 1; done_dst = 5'd6; step(); idle();
    check("R12 forwarded ready", 64'(exec_ready[2]), 1);
    check("R12 no waiters", 64'(woken_count), 0);
    insert(4, 0, 2, 8, 0, 0, 1, 0, 0, 0, 0);
    set_ins(3, 0, 3, 0, 0, 1, 1, 6, 1, 0, 0);
    done_valid = 1; done_dst = 5'd6; step(); idle();
    check("R12 insert clear wins", 64'(reg_ready[6]), 0);
    check("R12 no fault", 64'(producer_fault), 0);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    t_reset();
    t_wakeup();
    t_inflight();
    t_fault();
    t_range();
    t_squash();
    t_nonspec();
    t_drop();
    t_collide();
    summary();
  end

endmodule